// File: doc/BRIEF.md
# Register-mapped SPI master

This block is a serial peripheral interface master that software drives through a small 32-bit register bus with write and read strobes and a word address. Words written to the data register queue in a four-entry transmit buffer. The serial engine takes each word in turn and shifts it out on the data-out line. At the same time it assembles a word from the data-in line, and that word goes into a four-entry receive buffer that reads of the data register drain.

The block has two operating modes. In configuration mode software sets the clock divider, the word length (8 or 16 bits), the clock polarity, the clock phase and the bit order. In active mode the engine shifts queued words. A clear command empties both buffers. A status register reports both fill levels, an idle flag and a receive-level flag. A programmable receive fill level raises a level-sensitive interrupt, so software can queue up to four words, sleep, and then collect the replies in one burst. Chip select is left to an external general-purpose pin.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the block is in configuration mode (master control reads 0x40), both buffers are empty, status bit 2 (idle) reads 1, the interrupt is low and SCK is low.
- R2: Master control (word address 0) bits [7:6] select the mode: 01 is configuration and 10 is active. A queued word starts shifting only in active mode with the stop bit (bit 1) clear.
- R3: Writing master control with bit 0 set empties both buffers in the same cycle.
- R4: A write to the data register (word address 6) pushes bits [15:0] into the transmit buffer. A push into a full buffer (4 words) is dropped. Status bits [13:11] give the transmit count.
- R5: A read of the data register pops the receive buffer and returns 0 when that buffer is empty. A word that completes while the buffer holds 4 words is dropped. Status bits [10:8] give the receive count.
- R6: Control 1 (word address 2) and the format bits [2:0] of control 0 (word address 1) change only when written in configuration mode. The receive level field [13:12] and the interrupt enable bit 9 of control 0 change in either mode.
- R7: Each bit lasts n+1 clocks, where n is control 1 bits [15:8] and n=0 is treated as 1. SCK rests at the polarity level when no word is shifting.
- R8: Control 1 bits [7:0] equal to 16 select 16-bit words, and any other value selects 8-bit words. Received 8-bit words read back zero-extended.
- R9: Control 0 bit 0 is clock polarity, bit 1 is clock phase (0: the line is sampled on the leading edge; 1: data changes on the leading edge and is sampled on the trailing edge) and bit 2 selects most-significant-bit first. With data-out looped to data-in, every word returns unchanged.
- R10: Status bit 2 reads 1 exactly when no word is shifting and the transmit buffer is empty.
- R11: Status bit 14 is 1 while the receive count is at least control 0 [13:12] plus one. The interrupt equals that flag ANDed with control 0 bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the SCK base clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive buffer at the data address) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level-sensitive receive interrupt |

## Verification
The hardest case to reach from the ports is a word that completes while the receive buffer is already full, especially when a pop or a push arrives on the same edge. The bench fills the receive buffer with four looped-back words, queues a fifth word, and lets it complete against the full buffer. It separately parks four words behind the stop bit to show the transmit buffer saturating and the clear command emptying it. A behavioural model with queues tracks both fill levels, the shifting window and the interrupt on every clock, so a mismatch at any of these edges shows up in the cycle where it occurs.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    localparam int AW = 3;
    localparam logic [AW-1:0] A_MCTL = 3'd0;
    localparam logic [AW-1:0] A_FMT  = 3'd1;
    localparam logic [AW-1:0] A_RATE = 3'd2;
    localparam logic [AW-1:0] A_STAT = 3'd5;
    localparam logic [AW-1:0] A_DATA = 3'd6;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_CFG = 2'b01,
        MODE_RUN = 2'b10,
        MODE_RSV = 2'b11
    } mode_e;

    typedef struct packed {
        logic msb_first;
        logic cpha;
        logic cpol;
    } fmt_t;

    // clocks spent at the resting level before the leading edge
    function automatic logic [7:0] lead_cycles(logic [7:0] d);
        logic [8:0] s;
        s = (9'(d) + 9'd2) >> 1;
        return s[7:0];
    endfunction

    function automatic logic [7:0] eff_div(logic [7:0] d);
        return (d == 8'd0) ? 8'd1 : d;
    endfunction
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clr,
    input  logic                             push,
    input  logic [WIDTH-1:0]                 din,
    input  logic                             pop,
    output logic [WIDTH-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]       count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic             full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rp];

    function automatic logic [PW-1:0] step(logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift
    import spi_host_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] word,
    input  fmt_t          fmt,
    input  logic [7:0]    div,
    input  logic          wide,
    input  logic          miso,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_word,
    output logic          sck,
    output logic          mosi
);
    localparam int IW = $clog2(DW);
    localparam int KW = IW + 1;

    logic [7:0]    cnt, div_q, lead;
    logic [KW-1:0] bitk;
    logic [DW-1:0] tx_q, rx_q;
    fmt_t          fmt_q;
    logic          wide_q, mosi_q, lead_e, trail_e, last_bit;

    function automatic logic [IW-1:0] pos(logic msb, logic w, logic [KW-1:0] k);
        int last;
        last = w ? DW - 1 : DW / 2 - 1;
        return msb ? IW'(last - int'(k)) : IW'(k);
    endfunction

    assign lead     = lead_cycles(div_q);
    assign lead_e   = busy && (cnt == lead - 8'd1);
    assign trail_e  = busy && (cnt == div_q);
    assign last_bit = (bitk == (wide_q ? KW'(DW - 1) : KW'(DW / 2 - 1)));
    assign sck      = busy ? (fmt_q.cpol ^ (cnt >= lead)) : fmt.cpol;
    assign mosi     = mosi_q;
    assign rx_word  = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            bitk   <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            fmt_q  <= '0;
            div_q  <= 8'd1;
            wide_q <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                busy   <= 1'b1;
                cnt    <= '0;
                bitk   <= '0;
                tx_q   <= word;
                rx_q   <= '0;
                fmt_q  <= fmt;
                div_q  <= eff_div(div);
                wide_q <= wide;
                if (!fmt.cpha) mosi_q <= word[pos(fmt.msb_first, wide, '0)];
            end else if (lead_e) begin
                cnt <= cnt + 8'd1;
                if (!fmt_q.cpha) rx_q[pos(fmt_q.msb_first, wide_q, bitk)] <= miso;
                else             mosi_q <= tx_q[pos(fmt_q.msb_first, wide_q, bitk)];
            end else if (trail_e) begin
                cnt <= '0;
                if (fmt_q.cpha) rx_q[pos(fmt_q.msb_first, wide_q, bitk)] <= miso;
                if (last_bit) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    bitk <= bitk + KW'(1);
                    if (!fmt_q.cpha)
                        mosi_q <= tx_q[pos(fmt_q.msb_first, wide_q, bitk + KW'(1))];
                end
            end else if (busy) begin
                cnt <= cnt + 8'd1;
            end
        end
    end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int DW         = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          sck,
    output logic          mosi,
    input  logic          miso,
    output logic          irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    mode_e         mode_q;
    logic          stop_q, rxie_q;
    fmt_t          fmt_q;
    logic [1:0]    thr_q;
    logic [7:0]    div_q, bits_q;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [DW-1:0] tx_head, rx_head, rx_word;
    logic          fifo_clr, rate_wr, fmt_wr, tx_push, rx_pop, start, busy, done;
    logic          idle, rx_flag, cfg_mode;
    logic          unused_hi;

    assign unused_hi = ^bus_wdata[31:16];
    assign cfg_mode  = (mode_q == MODE_CFG);
    assign fifo_clr  = bus_wr && (bus_addr == A_MCTL) && bus_wdata[0];
    assign rate_wr   = bus_wr && (bus_addr == A_RATE);
    assign fmt_wr    = bus_wr && (bus_addr == A_FMT);
    assign tx_push   = bus_wr && (bus_addr == A_DATA);
    assign rx_pop    = bus_rd && (bus_addr == A_DATA);
    assign start     = (mode_q == MODE_RUN) && !stop_q && (tx_cnt != '0) && !busy;
    assign idle      = !busy && (tx_cnt == '0);
    assign rx_flag   = (32'(rx_cnt) >= 32'(thr_q) + 32'd1);
    assign irq       = rx_flag && rxie_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_CFG;
            stop_q <= 1'b0;
            fmt_q  <= '0;
            thr_q  <= '0;
            rxie_q <= 1'b0;
            div_q  <= 8'd1;
            bits_q <= 8'd8;
        end else if (bus_wr) begin
            if (bus_addr == A_MCTL) begin
                mode_q <= mode_e'(bus_wdata[7:6]);
                stop_q <= bus_wdata[1];
            end
            if (fmt_wr) begin
                thr_q  <= bus_wdata[13:12];
                rxie_q <= bus_wdata[9];
                if (cfg_mode) fmt_q <= fmt_t'(bus_wdata[2:0]);
            end
            if (rate_wr && cfg_mode) begin
                div_q  <= bus_wdata[15:8];
                bits_q <= bus_wdata[7:0];
            end
        end
    end

    spi_host_fifo #(.WIDTH(DW), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst(rst), .clr(fifo_clr),
        .push(tx_push), .din(bus_wdata[DW-1:0]),
        .pop(start), .dout(tx_head), .count(tx_cnt)
    );

    spi_host_fifo #(.WIDTH(DW), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst(rst), .clr(fifo_clr),
        .push(done), .din(rx_word),
        .pop(rx_pop), .dout(rx_head), .count(rx_cnt)
    );

    spi_host_shift #(.DW(DW)) shift_i (
        .clk(clk), .rst(rst), .start(start), .word(tx_head),
        .fmt(fmt_q), .div(div_q), .wide(bits_q == 8'd16), .miso(miso),
        .busy(busy), .done(done), .rx_word(rx_word), .sck(sck), .mosi(mosi)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MCTL: bus_rdata = {24'b0, mode_q, 4'b0, stop_q, 1'b0};
            A_FMT:  bus_rdata = {18'b0, thr_q, 2'b0, rxie_q, 6'b0, fmt_q};
            A_RATE: bus_rdata = {16'b0, div_q, bits_q};
            A_STAT: bus_rdata = {16'b0, 1'b0, rx_flag, 3'(tx_cnt), 3'(rx_cnt), 5'b0, idle, 2'b0};
            A_DATA: bus_rdata = (rx_cnt == '0) ? 32'b0 : {{(32-DW){1'b0}}, rx_head};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [1:0]                 mode,
    input logic                       stop,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic                       clr,
    input logic                       rate_wr,
    input logic [15:0]                rate,
    input logic [1:0]                 thr,
    input logic                       irq
);
    a_r4_tx_bound: assert property (@(posedge clk) disable iff (rst)
        32'(tx_cnt) <= DEPTH);

    a_r5_rx_bound: assert property (@(posedge clk) disable iff (rst)
        32'(rx_cnt) <= DEPTH);

    a_r2_start_gate: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt < $past(tx_cnt) && !$past(clr)) |-> ($past(mode) == 2'b10 && !$past(stop)));

    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (tx_cnt == '0 && rx_cnt == '0));

    a_r6_cfg_lock: assert property (@(posedge clk) disable iff (rst)
        (rate_wr && mode != 2'b01) |=> $stable(rate));

    a_r11_irq_level: assert property (@(posedge clk) disable iff (rst)
        irq |-> (32'(rx_cnt) > 32'(thr)));
endmodule

bind spi_host_regs spi_host_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
    .clk(clk), .rst(rst), .mode(mode_q), .stop(stop_q),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .clr(fifo_clr), .rate_wr(rate_wr),
    .rate({div_q, bits_q}), .thr(thr_q), .irq(irq)
);

// File: tb/spi_host_regs_tb_top.sv
module spi_host_regs_tb_top;
    logic clk = 1'b0, rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic sck, mosi, miso, irq;
    logic miso_one = 1'b0;

    assign miso = miso_one ? 1'b1 : mosi;
    always #5 clk = ~clk;

    spi_host_regs dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
        .miso(miso), .irq(irq)
    );

    int checks = 0, errors = 0;
    int cyc = 0, edges = 0, first_rise = 0, last_rise = 0;
    logic [15:0] cap = '0;

    // behavioural reference model
    int unsigned mtx[$], mrx[$];
    int m_mode = 1, m_stop = 0, m_thr = 0, m_en = 0, m_div = 1, m_bits = 8, m_fmt = 0;
    bit m_busy = 0, m_done = 0;
    int m_rem = 0;
    int unsigned m_cur = 0, m_dval = 0;

    task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mtx.delete(); mrx.delete();
            m_mode = 1; m_stop = 0; m_thr = 0; m_en = 0; m_div = 1; m_bits = 8; m_fmt = 0;
            m_busy = 0; m_done = 0; m_rem = 0;
        end else begin
            bit clr, st, pv;
            int unsigned pval;
            clr  = bus_wr && bus_addr == 3'd0 && bus_wdata[0];
            st   = !m_busy && m_mode == 2 && m_stop == 0 && mtx.size() > 0;
            pv   = m_done; pval = m_dval; m_done = 0;
            if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin m_busy = 0; m_done = 1; m_dval = m_cur; end
            end
            if (st) begin
                int unsigned v, mask;
                int w, n;
                v = mtx.pop_front();
                w = (m_bits == 16) ? 16 : 8;
                n = (m_div == 0) ? 1 : m_div;
                mask = (w == 16) ? 32'hFFFF : 32'hFF;
                m_cur = miso_one ? mask : (v & mask);
                m_busy = 1; m_rem = w * (n + 1);
            end
            if (bus_rd && bus_addr == 3'd6 && mrx.size() > 0) void'(mrx.pop_front());
            if (pv && mrx.size() < 4) mrx.push_back(pval);
            if (bus_wr && bus_addr == 3'd6 && mtx.size() < 4) mtx.push_back(bus_wdata[15:0]);
            if (clr) begin mtx.delete(); mrx.delete(); end
            if (bus_wr && bus_addr == 3'd1) begin
                m_thr = bus_wdata[13:12]; m_en = bus_wdata[9];
                if (m_mode == 1) m_fmt = bus_wdata[2:0];
            end
            if (bus_wr && bus_addr == 3'd2 && m_mode == 1) begin
                m_div = bus_wdata[15:8]; m_bits = bus_wdata[7:0];
            end
            if (bus_wr && bus_addr == 3'd0) begin
                m_mode = bus_wdata[7:6]; m_stop = bus_wdata[1];
            end
        end
    end

    // every-clock comparison: interrupt (R11) and resting SCK level (R7)
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_irq;
            exp_irq = (mrx.size() >= m_thr + 1) && m_en != 0;
            chk(irq == exp_irq, "R11 irq per clock", irq, exp_irq);
            if (!m_busy) chk(sck == m_fmt[0], "R7 sck rest level", sck, m_fmt[0]);
        end
    end

    always @(posedge sck) begin
        edges++;
        if (edges == 1) first_rise = cyc;
        last_rise = cyc;
        cap = {cap[14:0], mosi};
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy || m_done || mtx.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic stat_vs_model(input string tag);
        logic [31:0] s;
        bit exp_idle, exp_flag;
        exp_idle = !m_busy && mtx.size() == 0;
        exp_flag = mrx.size() >= m_thr + 1;
        bus_addr = 3'd5;
        #1 s = bus_rdata;
        chk(s[13:11] == mtx.size(), {tag, " R4 tx count"}, s[13:11], mtx.size());
        chk(s[10:8] == mrx.size(), {tag, " R5 rx count"}, s[10:8], mrx.size());
        chk(s[2] == exp_idle, {tag, " R10 idle"}, s[2], exp_idle);
        chk(s[14] == exp_flag, {tag, " R11 level flag"}, s[14], exp_flag);
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [31:0] rate, input logic [31:0] fmt);
        wr(3'd0, 32'h40);
        wr(3'd2, rate);
        wr(3'd1, fmt);
        wr(3'd0, 32'h80);
    endtask

    task automatic rate_check(input logic [31:0] rate, input int exp_span);
        set_cfg(rate, 32'h4);
        edges = 0;
        wr(3'd6, 32'h5A);
        wait_idle();
        chk(last_rise - first_rise == exp_span, "R7 bit period", last_rise - first_rise, exp_span);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, d); chk(d == 32'h40, "R1 reset mode", d, 32'h40);
        rd(3'd5, d); chk(d == 32'h4, "R1 reset status", d, 32'h4);
        chk(irq == 1'b0, "R1 irq low", irq, 0);
        chk(sck == 1'b0, "R1 sck low", sck, 0);
        stat_vs_model("reset");

        // R9 MSB first, mode 0, R7 edge count
        set_cfg(32'h0108, 32'h4);
        edges = 0; cap = '0;
        wr(3'd6, 32'h1E);
        wait_idle();
        chk(cap[7:0] == 8'h1E, "R9 msb-first order", cap[7:0], 8'h1E);
        chk(edges == 8, "R7 sck edges per word", edges, 8);
        rd(3'd6, d); chk(d == 32'h1E, "R9 loopback msb", d, 32'h1E);

        // R9 LSB first
        set_cfg(32'h0108, 32'h0);
        edges = 0; cap = '0;
        wr(3'd6, 32'h1E);
        wait_idle();
        chk(cap[7:0] == 8'h78, "R9 lsb-first order", cap[7:0], 8'h78);
        rd(3'd6, d); chk(d == 32'h1E, "R9 loopback lsb", d, 32'h1E);

        // R7 divider timing, including n=0 treated as 1
        rate_check(32'h0308, 28);
        rate_check(32'h0008, 14);
        rd(3'd6, d); rd(3'd6, d);

        // R8 16-bit, R9 cpol=1 cpha=1 lsb-first, R11 threshold 4 with enable
        set_cfg(32'h0210, 32'h3203);
        wr(3'd6, 32'hBEEF); wr(3'd6, 32'h1234); wr(3'd6, 32'h8001); wr(3'd6, 32'h7FFE);
        stat_vs_model("busy16");
        wait_idle();
        chk(irq == 1'b1, "R11 irq at level", irq, 1);
        stat_vs_model("full16");
        rd(3'd6, d); chk(d == 32'hBEEF, "R8 16-bit word 0", d, 32'hBEEF);
        chk(irq == 1'b0, "R11 irq drops below level", irq, 0);
        rd(3'd6, d); chk(d == 32'h1234, "R9 cpha1 word 1", d, 32'h1234);
        rd(3'd6, d); chk(d == 32'h8001, "R9 cpha1 word 2", d, 32'h8001);
        rd(3'd6, d); chk(d == 32'h7FFE, "R9 cpha1 word 3", d, 32'h7FFE);

        // R8 zero extension with miso held high
        set_cfg(32'h0108, 32'h0004);
        miso_one = 1'b1;
        wr(3'd6, 32'h0);
        wait_idle();
        miso_one = 1'b0;
        rd(3'd6, d); chk(d == 32'hFF, "R8 zero-extended 8-bit", d, 32'hFF);

        // R2 stop bit holds words, R4 overflow, R3 clear
        wr(3'd0, 32'h82);
        for (int i = 0; i < 5; i++) wr(3'd6, 32'h10 + i);
        repeat (20) @(negedge clk);
        rd(3'd5, d);
        chk(d[13:11] == 3'd4, "R4 tx saturates at 4", d[13:11], 4);
        chk(d[10:8] == 3'd0, "R2 stop blocks shifting", d[10:8], 0);
        stat_vs_model("stopped");
        wr(3'd0, 32'h41);
        rd(3'd5, d); chk(d[13:11] == 3'd0, "R3 clear empties tx", d[13:11], 0);

        // R6 writes in active mode
        wr(3'd0, 32'h80);
        wr(3'd2, 32'h0510);
        rd(3'd2, d); chk(d == 32'h0108, "R6 rate locked in active", d, 32'h0108);
        wr(3'd1, 32'h1005);
        rd(3'd1, d); chk(d == 32'h1004, "R6 level updates, format locked", d, 32'h1004);

        // R5 receive overflow and empty read, R10 idle while shifting
        for (int i = 1; i <= 4; i++) wr(3'd6, 32'h11 * i);
        wait_idle();
        wr(3'd6, 32'h55);
        repeat (2) @(negedge clk);
        rd(3'd5, d); chk(d[2] == 1'b0, "R10 not idle while shifting", d[2], 0);
        wait_idle();
        rd(3'd5, d);
        chk(d[10:8] == 3'd4, "R5 rx holds 4 after overflow", d[10:8], 4);
        chk(d[2] == 1'b1, "R10 idle after drain", d[2], 1);
        for (int i = 1; i <= 4; i++) begin
            rd(3'd6, d);
            chk(d == 32'h11 * i, "R5 first four kept", d, 32'h11 * i);
        end
        rd(3'd6, d); chk(d == 32'h0, "R5 empty read is zero", d, 0);
        stat_vs_model("end");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule